// File: doc/BRIEF.md
# Four-Way Instruction Cache Lookup

This block is the lookup and refill core of a read-only instruction cache with four ways of 256 lines, each line eight 32-bit words. A fetch request carries a virtual address and the 19-bit physical tag that the address translation unit produced for it. The virtual address picks the set and the word within the line. The four stored tags of that set are compared with the physical tag in parallel, and the single matching valid way supplies the word.

When no way matches, the block holds a fill request with the physical line address and takes the line back as eight word beats. It writes them into the way that the set's pairwise-age replacement state names as oldest. The requester then issues the fetch again and gets a hit.

Two resets are kept apart. Power-on reset invalidates every line and restores the replacement state. Manual reset only puts the control path back to idle, so lines fetched before it still hit. Tag storage has no reset of any kind.

Top module: `icache4_lookup`

## Requirements
- R1: Virtual address bits [12:5] pick the set and bits [4:2] pick the word. A hit returns on `rsp_data` the word written at that position of the hitting line.
- R2: A way hits only if its line is valid and its stored tag equals `req_ptag`. A miss is reported when any tag bit differs, or when the same tag sits in another set.
- R3: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 in the following cycle only, and `req_ready` is 1 only while the block is idle.
- R4: After a miss, `fill_req` stays 1 until the fill ends. While it is 1, `fill_addr` is constant and equals {tag, vaddr[9:5], 5'b00000}, and `req_ready` is 0.
- R5: Fill beats are taken on cycles with `fill_valid` 1, in word order 0 to 7. The line becomes valid only on the eighth beat. The way being replaced is invalidated when the fill begins.
- R6: Each set keeps six pairwise age bits. Every hit or completed fill makes the accessed way the most recent. A fill replaces the way that is older than all three others. After power-on reset the replacement order of every set is way 0, 1, 2, 3.
- R7: Power-on reset (`por`) invalidates all lines, restores the replacement order of R6 and abandons any fill. After it, every lookup misses.
- R8: Manual reset (`mrst`) abandons any fill and returns the block to idle with `fill_req` 0. It leaves line valid bits and age bits unchanged, so completed fills still hit afterwards.
- R9: At most one way reports a hit for any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| mrst | input | 1 | Manual reset, synchronous, active high |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_vaddr | input | 32 | Virtual fetch address |
| req_ptag | input | 19 | Physical tag from translation |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup found a valid matching way |
| rsp_way | output | 2 | Hitting way number |
| rsp_data | output | 32 | Selected word of the hitting line |
| fill_req | output | 1 | Line fill wanted |
| fill_addr | output | 29 | Physical address of the missing line |
| fill_valid | input | 1 | Fill beat present |
| fill_data | input | 32 | Fill beat word |

## Verification
The embedded assertions watch four things on every cycle: that at most one way hits, that a taken request yields a response in the next cycle, that the fill address is held for the whole fill, and that a manual reset leaves the valid and age bits of the addressed set untouched. They also check that a way just touched is never named as the next victim of its set. Which way a fill lands in after a sequence of hits, that a line cut off at seven beats stays invalid, and that every line is lost after power-on reset but kept through manual reset can only be shown by the bench. It does so by comparing each response against its own recency model of tags, valid bits and access stamps.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int NWAY = 4;
  localparam int NPAIR = 6;

  typedef logic [1:0]       way_t;
  typedef logic [NPAIR-1:0] age_t;
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_FILL} cstate_t;

  // age bit for pair (i,j), i<j: 1 means way i was used more recently than way j
  function automatic int pair_ix(input int i, input int j);
    int p;
    p = 0;
    for (int a = 0; a < NWAY; a++)
      for (int b = a + 1; b < NWAY; b++) begin
        if (a == i && b == j) pair_ix = p;
        p++;
      end
  endfunction

  function automatic age_t age_touch(input age_t cur, input way_t w);
    age_t nx;
    nx = cur;
    for (int i = 0; i < NWAY; i++)
      for (int j = i + 1; j < NWAY; j++) begin
        if (i == int'(w)) nx[pair_ix(i, j)] = 1'b1;
        if (j == int'(w)) nx[pair_ix(i, j)] = 1'b0;
      end
    return nx;
  endfunction

  function automatic way_t age_victim(input age_t cur);
    way_t v;
    logic oldest;
    v = '0;
    for (int c = NWAY - 1; c >= 0; c--) begin
      oldest = 1'b1;
      for (int o = 0; o < NWAY; o++) begin
        if (o < c && !cur[pair_ix(o, c)]) oldest = 1'b0;
        if (o > c && cur[pair_ix(c, o)]) oldest = 1'b0;
      end
      if (oldest) v = way_t'(c);
    end
    return v;
  endfunction
endpackage

// File: rtl/ic_tag_store.sv
module ic_tag_store
  import icache_pkg::*;
#(
  parameter int SETS  = 256,
  parameter int TAG_W = 19,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                       clk,
  input  logic                       por,
  input  logic                       rd_en,
  input  logic [IDX_W-1:0]           rd_idx,
  input  logic [IDX_W-1:0]           look_idx,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  way_t                       wr_way,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic                       inv_en,
  input  way_t                       inv_way,
  output logic [NWAY-1:0][TAG_W-1:0] rd_tag,
  output logic [NWAY-1:0]            vld_row
);
  logic [NWAY-1:0] vld_q [SETS];

  for (genvar w = 0; w < NWAY; w++) begin : g_way
    logic [TAG_W-1:0] mem [SETS];
    always_ff @(posedge clk) begin
      if (wr_en && wr_way == way_t'(w)) mem[wr_idx] <= wr_tag;
      if (rd_en) rd_tag[w] <= mem[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      if (inv_en) vld_q[look_idx][inv_way] <= 1'b0;
      if (wr_en)  vld_q[wr_idx][wr_way]    <= 1'b1;
    end
  end

  assign vld_row = vld_q[look_idx];
endmodule

// File: rtl/ic_data_store.sv
module ic_data_store
  import icache_pkg::*;
#(
  parameter int SETS   = 256,
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(SETS * WORDS)
) (
  input  logic                        clk,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           rd_addr,
  input  logic                        wr_en,
  input  way_t                        wr_way,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [NWAY-1:0][DATA_W-1:0] rd_data
);
  for (genvar w = 0; w < NWAY; w++) begin : g_way
    logic [DATA_W-1:0] mem [SETS*WORDS];
    always_ff @(posedge clk) begin
      if (wr_en && wr_way == way_t'(w)) mem[wr_addr] <= wr_data;
      if (rd_en) rd_data[w] <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/ic_age_store.sv
module ic_age_store
  import icache_pkg::*;
#(
  parameter int SETS = 256,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             por,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  way_t             upd_way,
  output age_t             rd_row,
  output way_t             victim
);
  age_t age_q [SETS];

  always_ff @(posedge clk) begin
    if (por) begin
      for (int s = 0; s < SETS; s++) age_q[s] <= '0;
    end else if (upd_en) begin
      age_q[upd_idx] <= age_touch(age_q[upd_idx], upd_way);
    end
  end

  assign rd_row = age_q[rd_idx];
  assign victim = age_victim(rd_row);

  AST_TOUCHED_NOT_VICTIM: assert property (@(posedge clk) disable iff (por)
    upd_en && upd_idx == rd_idx |=> victim != $past(upd_way)); // R6
endmodule

// File: rtl/icache4_lookup.sv
module icache4_lookup
  import icache_pkg::*;
#(
  parameter int SETS   = 256,
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 19,
  parameter int VA_W   = 32,
  parameter int PA_W   = 29,
  localparam int IDX_W   = $clog2(SETS),
  localparam int OFF_W   = $clog2(WORDS),
  localparam int LINE_LO = OFF_W + 2,
  localparam int PG_W    = PA_W - TAG_W,
  localparam int MID_W   = PG_W - LINE_LO,
  localparam int ADDR_W  = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              por,
  input  logic              mrst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [TAG_W-1:0]  req_ptag,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_way,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fill_req,
  output logic [PA_W-1:0]   fill_addr,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data
);
  cstate_t          state_q;
  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] ptag_q;
  logic [MID_W-1:0] mid_q;
  logic [OFF_W-1:0] beat_q;
  way_t             vict_q;
  logic [PA_W-1:0]  faddr_q;

  logic [IDX_W-1:0] req_idx;
  logic [OFF_W-1:0] req_word;
  logic             accept;
  logic [NWAY-1:0][TAG_W-1:0]  tags;
  logic [NWAY-1:0][DATA_W-1:0] words;
  logic [NWAY-1:0] vld_row;
  logic [NWAY-1:0] hit_vec;
  logic            any_hit;
  way_t            hit_way;
  logic [DATA_W-1:0] hit_data;
  age_t            age_row;
  way_t            victim;

  logic look_now, fill_beat, fill_last;
  logic tag_wr, inv_en, age_upd;
  way_t age_way;

  assign req_idx  = req_vaddr[LINE_LO +: IDX_W];
  assign req_word = req_vaddr[2 +: OFF_W];
  assign accept   = req_valid && state_q == ST_IDLE && !mrst && !por;
  assign look_now = state_q == ST_LOOK && !mrst;
  assign fill_beat = state_q == ST_FILL && fill_valid && !mrst;
  assign fill_last = fill_beat && beat_q == OFF_W'(WORDS - 1);

  // tag compare and way selection
  always_comb begin
    hit_way  = '0;
    hit_data = '0;
    for (int w = 0; w < NWAY; w++) begin
      hit_vec[w] = vld_row[w] && tags[w] == ptag_q;
      if (hit_vec[w]) begin
        hit_way  = way_t'(w);
        hit_data = hit_data | words[w];
      end
    end
  end
  assign any_hit = |hit_vec;

  assign tag_wr  = fill_last;
  assign inv_en  = look_now && !any_hit;
  assign age_upd = (look_now && any_hit) || fill_last;
  assign age_way = fill_last ? vict_q : hit_way;

  ic_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .por(por),
    .rd_en(accept), .rd_idx(req_idx), .look_idx(idx_q),
    .wr_en(tag_wr), .wr_idx(idx_q), .wr_way(vict_q), .wr_tag(ptag_q),
    .inv_en(inv_en), .inv_way(victim),
    .rd_tag(tags), .vld_row(vld_row)
  );

  ic_data_store #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk(clk),
    .rd_en(accept), .rd_addr({req_idx, req_word}),
    .wr_en(fill_beat), .wr_way(vict_q), .wr_addr({idx_q, beat_q}),
    .wr_data(fill_data), .rd_data(words)
  );

  ic_age_store #(.SETS(SETS)) u_age (
    .clk(clk), .por(por), .rd_idx(idx_q),
    .upd_en(age_upd), .upd_idx(idx_q), .upd_way(age_way),
    .rd_row(age_row), .victim(victim)
  );

  always_ff @(posedge clk) begin
    if (por || mrst) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) state_q <= ST_LOOK;
        ST_LOOK: begin
          beat_q  <= '0;
          state_q <= any_hit ? ST_IDLE : ST_FILL;
        end
        ST_FILL: if (fill_beat) begin
          beat_q <= beat_q + 1'b1;
          if (fill_last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // datapath registers carry no reset
  always_ff @(posedge clk) begin
    if (accept) begin
      idx_q  <= req_idx;
      ptag_q <= req_ptag;
      mid_q  <= req_vaddr[LINE_LO +: MID_W];
    end
    if (look_now && !any_hit) begin
      vict_q  <= victim;
      faddr_q <= {ptag_q, mid_q, {LINE_LO{1'b0}}};
    end
  end

  assign req_ready = state_q == ST_IDLE;
  assign rsp_valid = state_q == ST_LOOK;
  assign rsp_hit   = rsp_valid && any_hit;
  assign rsp_way   = hit_way;
  assign rsp_data  = hit_data;
  assign fill_req  = state_q == ST_FILL;
  assign fill_addr = faddr_q;

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (por)
    rsp_valid |-> $countones(hit_vec) <= 1); // R9
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (por || mrst)
    accept |=> rsp_valid); // R3
  AST_FILL_ADDR_HELD: assert property (@(posedge clk) disable iff (por || mrst)
    fill_req && $past(fill_req) |-> $stable(fill_addr) && !req_ready); // R4
  AST_MRST_KEEPS_STATE: assert property (@(posedge clk) disable iff (por)
    mrst |=> $stable(vld_row) && $stable(age_row)); // R8
endmodule

// File: tb/icache4_lookup_tb.sv
module icache4_lookup_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 256;

  logic        clk = 1'b0;
  logic        por = 1'b1, mrst = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [18:0] req_ptag = '0;
  logic        rsp_valid, rsp_hit;
  logic [1:0]  rsp_way;
  logic [31:0] rsp_data;
  logic        fill_req;
  logic [28:0] fill_addr;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icache4_lookup dut_i (
    .clk(clk), .por(por), .mrst(mrst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_ptag(req_ptag),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_data(rsp_data),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_data(fill_data)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct { bit hit; int way; logic [31:0] data; string rq; } exp_t;
  exp_t sb[$];

  // reference model: valid, tag and recency stamp per set and way
  bit          m_vld [SETS][4];
  logic [18:0] m_tag [SETS][4];
  int          m_stamp [SETS][4];
  int          m_clock;
  int          m_victim;
  int          m_set;
  logic [18:0] m_ptag;

  function automatic logic [31:0] dval(logic [18:0] t, int s, int w);
    return {t, 8'(s), 2'b10, 3'(w)};
  endfunction

  function automatic logic [31:0] mkva(int s, int w);
    return {19'h0, 8'(s), 3'(w), 2'b00};
  endfunction

  task automatic check(bit ok, string rq, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic model_por();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 4; w++) begin
        m_vld[s][w] = 0;
        m_stamp[s][w] = w;
      end
    m_clock = 4;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rsp_valid && !finished) begin
      if (sb.size() == 0) check(0, "R3", "unexpected response", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_hit == e.hit, e.rq, "hit", rsp_hit, e.hit);
        if (e.hit) begin
          check(rsp_way == 2'(e.way), e.rq, "way", rsp_way, e.way);
          check(rsp_data == e.data, e.rq, "data", rsp_data, e.data);
        end
      end
    end
  end

  // driver: predicts, queues expected item, issues the request
  task automatic lookup(int s, int w, logic [18:0] t, string rq, output bit hit);
    exp_t e;
    int hw;
    hw = -1;
    for (int k = 0; k < 4; k++) if (m_vld[s][k] && m_tag[s][k] == t) hw = k;
    e.hit = (hw >= 0); e.way = hw; e.rq = rq;
    e.data = (hw >= 0) ? dval(t, s, w) : '0;
    hit = e.hit;
    if (hw >= 0) m_stamp[s][hw] = m_clock++;
    else begin
      m_victim = 0;
      for (int k = 1; k < 4; k++) if (m_stamp[s][k] < m_stamp[s][m_victim]) m_victim = k;
      m_vld[s][m_victim] = 0;
      m_set = s; m_ptag = t;
    end
    @(negedge clk);
    check(req_ready == 1'b1, "R3", "ready before request", req_ready, 1);
    sb.push_back(e);
    req_valid = 1'b1; req_vaddr = mkva(s, w); req_ptag = t;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R3", "ready during response", req_ready, 0);
  endtask

  task automatic fill(int nbeats);
    @(negedge clk);
    check(fill_req == 1'b1, "R4", "fill_req after miss", fill_req, 1);
    check(req_ready == 1'b0, "R4", "ready while filling", req_ready, 0);
    check(fill_addr == {m_ptag, 5'(m_set), 5'b0}, "R4", "fill_addr", fill_addr,
          {m_ptag, 5'(m_set), 5'b0});
    for (int b = 0; b < nbeats; b++) begin
      fill_valid = 1'b1;
      fill_data  = dval(m_ptag, m_set, b);
      if (b == 3) begin
        // one idle beat in the middle
        fill_valid = 1'b0;
        @(negedge clk);
        fill_valid = 1'b1;
      end
      @(negedge clk);
    end
    fill_valid = 1'b0;
    if (nbeats == 8) begin
      m_vld[m_set][m_victim] = 1;
      m_tag[m_set][m_victim] = m_ptag;
      m_stamp[m_set][m_victim] = m_clock++;
      check(fill_req == 1'b0, "R5", "fill_req after 8th beat", fill_req, 0);
    end
  endtask

  task automatic access(int s, int w, logic [18:0] t, string rq);
    bit h;
    lookup(s, w, t, rq, h);
    if (!h) fill(8);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(0, "R3", "watchdog expired", 0, 1);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    bit h;
    model_por();
    repeat (3) @(posedge clk);
    @(negedge clk); por = 1'b0;
    // R7 reset state
    check(rsp_valid == 1'b0, "R7", "rsp_valid after por", rsp_valid, 0);
    check(fill_req == 1'b0, "R7", "fill_req after por", fill_req, 0);
    check(req_ready == 1'b1, "R7", "req_ready after por", req_ready, 1);

    // R6: four fills of set 5 land in ways 0..3; R1 words differ
    for (int k = 0; k < 4; k++) access(5, k, 19'h100 + 19'(k), "R6");
    for (int k = 0; k < 4; k++) access(5, 7 - k, 19'h100 + 19'(k), "R1");
    // R6: touch tag 0x100 then 0x102; new tag replaces oldest (0x101, way 1)
    access(5, 2, 19'h100, "R6");
    access(5, 2, 19'h102, "R6");
    access(5, 4, 19'h1AA, "R6");
    access(5, 4, 19'h1AA, "R6");
    access(5, 6, 19'h101, "R6");
    // R2: one-bit tag difference and same tag in another set miss
    access(5, 0, 19'h100 ^ 19'h40000, "R2");
    access(200, 3, 19'h102, "R2");
    access(200, 3, 19'h102, "R2");
    access(5, 1, 19'h103, "R2");

    // R5: fill cut after seven beats by manual reset leaves line invalid
    lookup(9, 0, 19'h7ABCD, "R5", h);
    fill(7);
    pulse(mrst);
    @(negedge clk);
    check(fill_req == 1'b0, "R8", "fill_req after mrst", fill_req, 0);
    check(req_ready == 1'b1, "R8", "ready after mrst", req_ready, 1);
    access(9, 5, 19'h7ABCD, "R5");
    access(9, 5, 19'h7ABCD, "R5");

    // R8: manual reset keeps lines and ages
    pulse(mrst);
    access(200, 6, 19'h102, "R8");
    access(5, 3, 19'h1AA, "R8");
    access(9, 7, 19'h7ABCD, "R8");
    access(5, 0, 19'h3FFFF, "R8");

    // R7: power-on reset loses every line, order restarts at way 0
    pulse(por);
    model_por();
    access(200, 6, 19'h102, "R7");
    access(9, 7, 19'h7ABCD, "R7");
    access(5, 3, 19'h1AA, "R7");
    access(5, 3, 19'h1AA, "R7");
    access(9, 1, 19'h7ABCD, "R9");

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R3", "responses outstanding", sb.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule